// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Selector

This block collects a set of level interrupt sources (32 or 64), gates each one with its own enable bit, and raises a single registered summary interrupt whenever any enabled source is active. Software reaches the enable bits and the raw source levels through a narrow port that handles one 32-bit word at a time. The port can load a whole word, set chosen bits, clear chosen bits, or only read.

When the handler wants to know which source to serve, it pulses a service request. The block then returns one pending source. The search starts at a rotating pointer, and after each successful pick the pointer moves to the entry just past the chosen one. Because of this, no source can starve another. In the wide configuration the word addresses are reversed: the highest source group sits at word 0. A contiguous window of source indices can be marked as cascaded external lines. A pick inside that window is reported with an external flag and a line number counted from the start of the window.

Top module: `rr_irq_sel`

## Requirements
- R1: A source is pending when its status input and its enable bit are both 1. `irq_out` equals the OR of all pending bits as they stood at the previous rising clock edge.
- R2: Synchronous active-high reset clears every enable bit, sets the rotating pointer to 0, and drives `irq_out`, `svc_valid`, `svc_idx`, `svc_ext`, `svc_num`, `rd_stat` and `rd_mask` to 0.
- R3: Word address `a` reaches sources 32*g to 32*g+31, where g = a XOR (words-1). With 64 sources, word 0 holds sources 32..63 and word 1 holds sources 0..31. An address with no group behind it reads 0 and writes nothing.
- R4: When `cfg_en` is 1, `cfg_op` selects the update of the addressed word: 0 = hold, 1 = OR `cfg_wdata` into the enables, 2 = clear the enables where `cfg_wdata` is 1, 3 = load `cfg_wdata`. No other enable bit changes, and when `cfg_en` is 0 nothing changes.
- R5: `rd_stat` and `rd_mask` show the status and enable word at `cfg_word`, registered one cycle. `rd_mask` gives the enable value from before any update made at that same edge.
- R6: A one-cycle `svc_req` produces, in the next cycle, `svc_valid`=1 and `svc_idx` equal to the first pending source found when scanning upward from the pointer and wrapping past the top index.
- R7: After a pick, the pointer equals the picked index plus 1, modulo the source count.
- R8: If no source is pending at a request, or no request is made, `svc_valid` is 0 in the next cycle, `svc_idx`/`svc_ext`/`svc_num` are 0, and the pointer stays where it was.
- R9: With cascading enabled, a pick with index in [CASC_LO, CASC_HI] gives `svc_ext`=1 and `svc_num` = index minus CASC_LO. Any other pick gives `svc_ext`=0 and `svc_num` = index.
- R10: Two sources that are both held pending are served in alternation under back-to-back requests, whatever their indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_stat | input | NUM_SRC | Raw source levels |
| cfg_en | input | 1 | Enable-word update strobe |
| cfg_op | input | 2 | Update operation (hold/set/clear/load) |
| cfg_word | input | AW | Word address for update and readback |
| cfg_wdata | input | 32 | Update data |
| rd_stat | output | 32 | Registered status word at `cfg_word` |
| rd_mask | output | 32 | Registered enable word at `cfg_word` |
| irq_out | output | 1 | Registered summary interrupt |
| svc_req | input | 1 | Service request pulse |
| svc_valid | output | 1 | A source was picked for the last request |
| svc_idx | output | IW | Picked source index |
| svc_ext | output | 1 | Picked source is a cascaded external line |
| svc_num | output | IW | Line number (external or internal) |

## Verification
On every cycle the assertions check the following: reset clears the enables and outputs, a valid answer always follows a request and names a source that was pending at that edge, an empty request returns nothing, the pointer sits just past the last pick, and the external flag appears only inside the cascade window. Some behaviour depends on history and on the word layout, and only the bench's scenarios show it. This covers the first-pending choice in rotation order including wrap-around, alternation between two held sources, the reversed word addressing, and the exact effect of the set, clear and load operations against a reference model.

// File: rtl/rr_irq_pkg.sv
package rr_irq_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_LOAD = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/rr_mask_bank.sv
module rr_mask_bank #(
  parameter int NW = 2,
  parameter int WW = 32,
  parameter int AW = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NW*WW-1:0]     src_stat,
  input  logic                 cfg_en,
  input  logic [1:0]           cfg_op,
  input  logic [AW-1:0]        cfg_word,
  input  logic [WW-1:0]        cfg_wdata,
  output logic [NW*WW-1:0]     mask_all,
  output logic [WW-1:0]        rd_stat,
  output logic [WW-1:0]        rd_mask
);
  import rr_irq_pkg::*;

  localparam logic [AW-1:0] FLIP = AW'(NW - 1);

  logic [AW-1:0] grp;
  logic          grp_ok;
  cfg_op_e       op;

  assign grp    = cfg_word ^ FLIP;
  assign grp_ok = (int'(grp) < NW);
  assign op     = cfg_op_e'(cfg_op);

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic          hit;
    logic [WW-1:0] cur;
    assign hit = cfg_en && grp_ok && (int'(grp) == w);
    assign cur = mask_all[w*WW +: WW];

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_all[w*WW +: WW] <= '0;
      end else if (hit) begin
        case (op)
          OP_SET:  mask_all[w*WW +: WW] <= cur | cfg_wdata;
          OP_CLR:  mask_all[w*WW +: WW] <= cur & ~cfg_wdata;
          OP_LOAD: mask_all[w*WW +: WW] <= cfg_wdata;
          default: mask_all[w*WW +: WW] <= cur;
        endcase
      end
    end
  end

  logic [WW-1:0] stat_sel, mask_sel;

  always_comb begin
    stat_sel = '0;
    mask_sel = '0;
    for (int w = 0; w < NW; w++) begin
      if (grp_ok && int'(grp) == w) begin
        stat_sel = src_stat[w*WW +: WW];
        mask_sel = mask_all[w*WW +: WW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat <= '0;
      rd_mask <= '0;
    end else begin
      rd_stat <= stat_sel;
      rd_mask <= mask_sel;
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic          req,
  output logic          hit,
  output logic [IW-1:0] pick,
  output logic [IW-1:0] ptr_q
);
  logic [2*N-1:0] dbl;
  logic [N-1:0]   rot;
  logic [IW-1:0]  first;

  assign dbl = {pend, pend} >> ptr_q;
  assign rot = dbl[N-1:0];
  assign hit = |pend;

  always_comb begin
    first = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) first = IW'(k);
    end
  end

  assign pick = ptr_q + first;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (req && hit) begin
      ptr_q <= pick + IW'(1);
    end
  end
endmodule

// File: rtl/rr_src_map.sv
module rr_src_map #(
  parameter int IW      = 6,
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 40,
  parameter int CASC_HI = 43
) (
  input  logic [IW-1:0] idx,
  output logic          ext,
  output logic [IW-1:0] num
);
  localparam logic [IW-1:0] LO_V = IW'(CASC_LO);
  localparam logic [IW-1:0] HI_V = IW'(CASC_HI);

  if (CASC_EN) begin : g_casc
    assign ext = (idx >= LO_V) && (idx <= HI_V);
  end else begin : g_flat
    assign ext = 1'b0;
  end

  assign num = ext ? (idx - LO_V) : idx;
endmodule

// File: rtl/rr_irq_sel.sv
module rr_irq_sel #(
  parameter int  NUM_SRC = 64,
  parameter bit  CASC_EN = 1'b1,
  parameter int  CASC_LO = 40,
  parameter int  CASC_HI = 43,
  localparam int WW      = rr_irq_pkg::WORD_W,
  localparam int NW      = NUM_SRC / WW,
  localparam int AW      = (NW > 1) ? $clog2(NW) : 1,
  localparam int IW      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_stat,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_op,
  input  logic [AW-1:0]      cfg_word,
  input  logic [WW-1:0]      cfg_wdata,
  output logic [WW-1:0]      rd_stat,
  output logic [WW-1:0]      rd_mask,
  output logic               irq_out,
  input  logic               svc_req,
  output logic               svc_valid,
  output logic [IW-1:0]      svc_idx,
  output logic               svc_ext,
  output logic [IW-1:0]      svc_num
);
  logic [NUM_SRC-1:0] mask_all;
  logic [NUM_SRC-1:0] pend;
  logic               pick_hit;
  logic [IW-1:0]      pick_idx;
  logic [IW-1:0]      ptr_q;
  logic               map_ext;
  logic [IW-1:0]      map_num;

  rr_mask_bank #(.NW(NW), .WW(WW), .AW(AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .src_stat  (src_stat),
    .cfg_en    (cfg_en),
    .cfg_op    (cfg_op),
    .cfg_word  (cfg_word),
    .cfg_wdata (cfg_wdata),
    .mask_all  (mask_all),
    .rd_stat   (rd_stat),
    .rd_mask   (rd_mask)
  );

  assign pend = src_stat & mask_all;

  rr_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .req   (svc_req),
    .hit   (pick_hit),
    .pick  (pick_idx),
    .ptr_q (ptr_q)
  );

  rr_src_map #(.IW(IW), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)) u_map (
    .idx (pick_idx),
    .ext (map_ext),
    .num (map_num)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      svc_valid <= 1'b0;
      svc_idx   <= '0;
      svc_ext   <= 1'b0;
      svc_num   <= '0;
    end else begin
      irq_out <= |pend;
      if (svc_req && pick_hit) begin
        svc_valid <= 1'b1;
        svc_idx   <= pick_idx;
        svc_ext   <= map_ext;
        svc_num   <= map_num;
      end else begin
        svc_valid <= 1'b0;
        svc_idx   <= '0;
        svc_ext   <= 1'b0;
        svc_num   <= '0;
      end
    end
  end
endmodule

// File: rtl/rr_irq_sel_chk.sv
module rr_irq_sel_chk #(
  parameter int N       = 64,
  parameter int IW      = 6,
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 40,
  parameter int CASC_HI = 43
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  src_stat,
  input logic [N-1:0]  mask_all,
  input logic [IW-1:0] ptr_q,
  input logic          irq_out,
  input logic          svc_req,
  input logic          svc_valid,
  input logic [IW-1:0] svc_idx,
  input logic          svc_ext
);
  logic [N-1:0] pend_q;
  logic         req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= src_stat & mask_all;
      req_q  <= svc_req;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (mask_all == '0 && ptr_q == '0 && !irq_out && !svc_valid)); // R2

  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|pend_q)); // R1

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> req_q); // R6

  AST_PICK_PENDING: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> pend_q[svc_idx]); // R6

  AST_EMPTY_NO_PICK: assert property (@(posedge clk) disable iff (rst)
    (req_q && pend_q == '0) |-> !svc_valid); // R8

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> (ptr_q == IW'(svc_idx + IW'(1)))); // R7

  AST_EXT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    svc_ext |-> (CASC_EN && int'(svc_idx) >= CASC_LO && int'(svc_idx) <= CASC_HI)); // R9
endmodule

bind rr_irq_sel rr_irq_sel_chk #(
  .N(NUM_SRC), .IW(IW), .CASC_EN(CASC_EN), .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_stat  (src_stat),
  .mask_all  (mask_all),
  .ptr_q     (ptr_q),
  .irq_out   (irq_out),
  .svc_req   (svc_req),
  .svc_valid (svc_valid),
  .svc_idx   (svc_idx),
  .svc_ext   (svc_ext)
);

// File: tb/sim_rr_irq_sel.sv
module sim_rr_irq_sel;
  localparam int N  = 64;
  localparam int LO = 40;
  localparam int HI = 43;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_stat = '0;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_op = 2'd0;
  logic [0:0]  cfg_word = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] rd_stat, rd_mask;
  logic        irq_out, svc_req = 1'b0, svc_valid, svc_ext;
  logic [5:0]  svc_idx, svc_num;

  always #4 clk = ~clk;

  rr_irq_sel #(.NUM_SRC(N), .CASC_EN(1'b1), .CASC_LO(LO), .CASC_HI(HI)) u0 (
    .clk(clk), .rst(rst), .src_stat(src_stat), .cfg_en(cfg_en), .cfg_op(cfg_op),
    .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .rd_stat(rd_stat), .rd_mask(rd_mask),
    .irq_out(irq_out), .svc_req(svc_req), .svc_valid(svc_valid), .svc_idx(svc_idx),
    .svc_ext(svc_ext), .svc_num(svc_num)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  bit [63:0] m_mask = '0;
  int        m_ptr  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, compare after the edge
  task automatic cyc(input bit r, input bit [63:0] st, input bit en, input bit [1:0] op,
                     input bit w, input bit [31:0] wd, input bit rq);
    bit [63:0] pend;
    bit        e_irq, e_val, e_ext;
    int        e_idx, e_num, g;
    bit [31:0] e_rs, e_rm;
    rst = r; src_stat = st; cfg_en = en; cfg_op = op; cfg_word = w;
    cfg_wdata = wd; svc_req = rq;
    e_irq = 0; e_val = 0; e_ext = 0; e_idx = 0; e_num = 0; e_rs = 0; e_rm = 0;
    if (r) begin
      m_mask = '0;
      m_ptr  = 0;
    end else begin
      pend  = st & m_mask;
      e_irq = (pend != 0);
      g     = w ? 0 : 1;          // reversed word order (R3)
      e_rs  = st[g*32 +: 32];
      e_rm  = m_mask[g*32 +: 32];
      if (rq) begin
        for (int j = 0; j < N; j++) begin
          int k;
          k = (m_ptr + j) % N;
          if (!e_val && pend[k]) begin
            e_val = 1; e_idx = k;
          end
        end
        if (e_val) begin
          m_ptr = (e_idx + 1) % N;
          e_ext = (e_idx >= LO && e_idx <= HI);
          e_num = e_ext ? e_idx - LO : e_idx;
        end
      end
      if (en) begin
        case (op)
          2'd1: m_mask[g*32 +: 32] = m_mask[g*32 +: 32] | wd;
          2'd2: m_mask[g*32 +: 32] = m_mask[g*32 +: 32] & ~wd;
          2'd3: m_mask[g*32 +: 32] = wd;
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(irq_out == e_irq, "R1", "irq_out", irq_out, e_irq);
    chk(rd_stat == e_rs, "R3", "rd_stat", rd_stat, e_rs);
    chk(rd_mask == e_rm, "R5", "rd_mask", rd_mask, e_rm);
    chk(svc_valid == e_val, e_val ? "R6" : "R8", "svc_valid", svc_valid, e_val);
    chk(svc_idx == 6'(e_idx), "R7", "svc_idx", svc_idx, e_idx);
    chk(svc_ext == e_ext, "R9", "svc_ext", svc_ext, e_ext);
    chk(svc_num == 6'(e_num), "R9", "svc_num", svc_num, e_num);
  endtask

  // convenience: write enables without other activity
  task automatic wr(input bit [1:0] op, input bit w, input bit [31:0] wd);
    cyc(0, '0, 1, op, w, wd, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [63:0] st;
    @(negedge clk);
    // R2: reset state
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 2'd3, 0, 32'hFFFF_FFFF, 1);
    cyc(1, '0, 0, 0, 0, 0, 0);
    chk(rd_mask == 0 && !irq_out && !svc_valid, "R2", "reset outputs", rd_mask, 0);
    // R2: enables start cleared, so full status raises nothing
    cyc(0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 1);
    // R3/R4: load word 0 -> sources 32..63; read both words back
    wr(2'd3, 0, 32'hF0F0_0001);
    cyc(0, 64'h0000_0001_0000_0001, 0, 0, 0, 0, 0);
    cyc(0, 64'h0000_0001_0000_0001, 0, 0, 1, 0, 0);
    // R4: set and clear touch only the chosen bits
    wr(2'd1, 1, 32'h8000_0005);
    wr(2'd2, 0, 32'h0000_F000);
    wr(2'd0, 1, 32'hFFFF_FFFF);            // hold op: no change
    cyc(0, '0, 0, 2'd3, 1, 32'h0, 0);       // cfg_en low: no change
    cyc(0, '0, 0, 0, 1, 0, 0);
    cyc(0, '0, 0, 0, 0, 0, 0);
    // R6/R7: rotate through several pending sources with wrap
    st = 64'h8000_0000_0000_0005 | (64'h1 << 32);
    for (int i = 0; i < 8; i++) cyc(0, st, 0, 0, 0, 0, 1);
    // R8: nothing pending -> no pick, pointer held
    cyc(0, '0, 0, 0, 0, 0, 1);
    cyc(0, st, 0, 0, 0, 0, 0);
    cyc(0, st, 0, 0, 0, 0, 1);
    // R10: two held sources alternate
    wr(2'd3, 0, 32'h0000_0000);
    wr(2'd3, 1, 32'h0000_0000);
    wr(2'd1, 1, 32'h0000_0008);            // source 3
    wr(2'd1, 0, 32'h0000_0400);            // source 42
    for (int i = 0; i < 6; i++) cyc(0, (64'h1 << 3) | (64'h1 << 42), 0, 0, 0, 0, 1);
    // R9: cascade window edges
    wr(2'd3, 0, 32'h0000_0F80);            // sources 39..43
    wr(2'd3, 1, 32'h0);
    for (int i = 0; i < 6; i++) cyc(0, 64'h0000_0F80_0000_0000, 0, 0, 0, 0, 1);
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      bit [63:0] rs;
      rs = {$urandom, $urandom} & {$urandom, $urandom};
      cyc(($urandom % 500) == 0, rs, ($urandom % 3) == 0, 2'($urandom),
          1'($urandom), $urandom, ($urandom % 2) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule